// File: doc/BRIEF.md
# RS-485 Driver-Enable Sequencer

This block steers the direction pin of a half-duplex RS-485 transceiver around the frames sent by a neighbouring UART transmitter. It watches two status lines from the transmitter, the transmit FIFO empty flag and the shift register busy flag, together with the one-per-bit-time tick from the baud generator. As soon as data is waiting or being shifted, the driver enable turns on. No delay is inserted before the start bit. Once the FIFO and the shifter are both empty, the enable stays on for a programmable number of bit times, from 0 to 15, and is then released.

A single 16-bit configuration register controls the sequencer. It holds a master enable, a routing bit that places the direction function on the RTS pin, a polarity bit and the 4-bit hold delay. When the direction function is not routed to the pin, the pin carries the ordinary modem-control RTS level. If fresh data shows up while the hold delay is counting, the countdown is cancelled, the enable stays on, and a full delay is counted again after the next idle point.

Top module: `dir_enable_seq`

## Requirements
- R1: After reset the configuration register reads 0x0000, `drv_en` is low and `rts_out` follows `modem_rts`.
- R2: A write with `cfg_we` high stores bit 0 (enable), bit 1 (pin route), bit 2 (polarity) and bits 11:8 (hold delay). The stored value is readable on `cfg_rdata` from the next cycle, and every other bit reads 0.
- R3: While enabled, `drv_en` is high in the same cycle in which the transmitter becomes active, meaning `tx_fifo_empty` is low or `tx_shift_busy` is high.
- R4: While enabled, `drv_en` stays high for every cycle in which the transmitter is active.
- R5: With a hold delay of N greater than 0, once the transmitter goes idle, `drv_en` stays high until N `bit_tick` pulses have been seen and drops in the cycle after the Nth tick. Cycles without a tick leave the countdown unchanged.
- R6: With a hold delay of 0, `drv_en` drops in the cycle after the first idle cycle.
- R7: If the transmitter becomes active again during the hold countdown, `drv_en` stays high, the countdown is abandoned, and a full delay is counted after the next idle point.
- R8: With enable and pin route both set, `rts_out` equals `drv_en` when polarity is 0 and equals its inverse when polarity is 1.
- R9: With enable clear, `drv_en` is low and any sequence in progress is abandoned. With enable clear or pin route clear, `rts_out` equals `modem_rts`.
- R10: `bit_tick` pulses while idle or while the transmitter is active have no effect on `drv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_shift_busy | input | 1 | Transmit shifter is sending a frame |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| modem_rts | input | 1 | Ordinary modem-control RTS level |
| drv_en | output | 1 | Active-high driver enable, before polarity |
| rts_out | output | 1 | Level driven onto the RTS pin |

## Verification
If the hold counter takes a wrong value, the release edge of `drv_en` and `rts_out` moves by whole bit times. That is visible at the first idle point after the error and at the latest 15 ticks later. A sequencer stuck out of idle holds the enable on through the whole idle gap that follows. The bench compares both outputs and the read-back every cycle, so such faults show within one frame. A polarity or routing mistake appears on `rts_out` in the first cycle after the configuration changes.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int CFG_W   = 16;
  localparam int DLY_W   = 4;
  localparam int EN_BIT  = 0;
  localparam int PIN_BIT = 1;
  localparam int POL_BIT = 2;
  localparam int DLY_LSB = 8;
  localparam int DLY_MSB = DLY_LSB + DLY_W - 1;

  typedef enum logic [1:0] {
    DS_IDLE   = 2'd0,
    DS_DRIVE  = 2'd1,
    DS_LINGER = 2'd2
  } dseq_state_e;

  typedef struct packed {
    logic [DLY_W-1:0] dly;
    logic             pol;
    logic             pin;
    logic             en;
  } dseq_cfg_t;

  function automatic dseq_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
    dseq_cfg_t c;
    c.en  = w[EN_BIT];
    c.pin = w[PIN_BIT];
    c.pol = w[POL_BIT];
    c.dly = w[DLY_MSB:DLY_LSB];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_to_word(input dseq_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[EN_BIT]          = c.en;
    w[PIN_BIT]         = c.pin;
    w[POL_BIT]         = c.pol;
    w[DLY_MSB:DLY_LSB] = c.dly;
    return w;
  endfunction
endpackage

// File: rtl/dseq_cfg_reg.sv
module dseq_cfg_reg
  import dseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output dseq_cfg_t        cfg,
  output logic [CFG_W-1:0] rdata
);
  localparam logic [CFG_W-1:0] KEEP_MASK = cfg_to_word('1);

  dseq_cfg_t cfg_q;
  dseq_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = cfg_from_word(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_to_word(cfg_q);

  // R2: a write is visible, masked, on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == ($past(wdata) & KEEP_MASK)));
  // R2: without a write the register keeps its value
  a_r2_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));
endmodule

// File: rtl/dseq_seq.sv
module dseq_seq
  import dseq_pkg::*;
#(
  parameter int CNT_W = DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] dly,
  input  logic             tx_active,
  input  logic             bit_tick,
  output logic             drv_en
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  dseq_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en) begin
      state_d = DS_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        DS_IDLE: begin
          if (tx_active) state_d = DS_DRIVE;
        end
        DS_DRIVE: begin
          if (!tx_active) begin
            if (dly == '0) begin
              state_d = DS_IDLE;
            end else begin
              state_d = DS_LINGER;
              cnt_d   = dly;
            end
          end
        end
        DS_LINGER: begin
          if (tx_active) begin
            state_d = DS_DRIVE;
            cnt_d   = '0;
          end else if (bit_tick) begin
            if (cnt_q == CNT_ONE) begin
              state_d = DS_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q - CNT_ONE;
            end
          end
        end
        default: begin
          state_d = DS_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign drv_en = en && ((state_q != DS_IDLE) || tx_active);

  // R4: once driving with data present, the enable survives into the next cycle
  a_r4_keep_driving: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && tx_active && en) |=> (drv_en || !en));
  // R5: the hold countdown never sits at zero
  a_r5_linger_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DS_LINGER) |-> (cnt_q != '0));
  // R5: without a tick the countdown does not move
  a_r5_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DS_LINGER && en && !tx_active && !bit_tick) |=>
      (state_q == DS_LINGER && $stable(cnt_q)));
  // R6: zero delay releases straight away
  a_r6_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DS_DRIVE && en && !tx_active && dly == '0) |=> (state_q == DS_IDLE));
  // R7: new data during the hold returns to driving
  a_r7_cancel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DS_LINGER && en && tx_active) |=> (state_q == DS_DRIVE));
  // R9: clearing enable abandons the sequence
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == DS_IDLE));
endmodule

// File: rtl/dseq_pin_mux.sv
module dseq_pin_mux (
  input  logic en,
  input  logic pin,
  input  logic pol,
  input  logic drv_en,
  input  logic modem_rts,
  output logic rts_out
);
  logic route;

  always_comb begin
    route   = en && pin;
    rts_out = route ? (drv_en ^ pol) : modem_rts;
  end
endmodule

// File: rtl/dir_enable_seq.sv
module dir_enable_seq
  import dseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             tx_fifo_empty,
  input  logic             tx_shift_busy,
  input  logic             bit_tick,
  input  logic             modem_rts,
  output logic             drv_en,
  output logic             rts_out
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       tx_active;
  dseq_cfg_t  cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign tx_active = !tx_fifo_empty || tx_shift_busy;

  dseq_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  dseq_seq #(.CNT_W(DLY_W)) u_seq (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .en        (cfg.en),
    .dly       (cfg.dly),
    .tx_active (tx_active),
    .bit_tick  (bit_tick),
    .drv_en    (drv_en)
  );

  dseq_pin_mux u_mux (
    .en        (cfg.en),
    .pin       (cfg.pin),
    .pol       (cfg.pol),
    .drv_en    (drv_en),
    .modem_rts (modem_rts),
    .rts_out   (rts_out)
  );

  // R3: an enabled sequencer drives whenever the transmitter has work
  a_r3_start_now: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cfg.en && tx_active) |-> drv_en);
  // R9: disabled means no drive
  a_r9_off_when_disabled: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cfg.en |-> !drv_en);
endmodule

// File: tb/sim_dir_enable_seq.sv
`timescale 1ns/1ps
module sim_dir_enable_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        tx_fifo_empty = 1'b1;
  logic        tx_shift_busy = 1'b0;
  logic        bit_tick = 1'b0;
  logic        modem_rts = 1'b0;
  logic        drv_en;
  logic        rts_out;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    tick_on = 1'b0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  dir_enable_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_fifo_empty(tx_fifo_empty),
    .tx_shift_busy(tx_shift_busy), .bit_tick(bit_tick),
    .modem_rts(modem_rts), .drv_en(drv_en), .rts_out(rts_out)
  );

  // tick generator: one pulse every fourth cycle when on
  int tdiv = 0;
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv + 1) % 4;
    bit_tick = tick_on && (tdiv == 0);
  end

  // behavioural reference: phase 0 quiet, 1 sending, 2 holding
  logic [15:0] m_cfg = '0;
  int          m_phase = 0;
  int          m_ticks_left = 0;

  always @(posedge clk) begin
    bit act;
    int dly;
    act = !tx_fifo_empty || tx_shift_busy;
    dly = int'(m_cfg[11:8]);
    if (!rst_n) begin
      m_cfg = '0; m_phase = 0; m_ticks_left = 0;
    end else begin
      if (!m_cfg[0]) m_phase = 0;
      else if (act) m_phase = 1;
      else if (m_phase == 1) begin
        if (dly == 0) m_phase = 0;
        else begin m_phase = 2; m_ticks_left = dly; end
      end else if (m_phase == 2 && bit_tick) begin
        m_ticks_left = m_ticks_left - 1;
        if (m_ticks_left == 0) m_phase = 0;
      end
      if (cfg_we) m_cfg = cfg_wdata & 16'h0F07;
    end
  end

  task automatic chk(input string what, input logic [15:0] act_v, input logic [15:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    bit act, de, rts;
    if (rst_n && !done) begin
      act = !tx_fifo_empty || tx_shift_busy;
      de  = m_cfg[0] && (m_phase != 0 || act);
      rts = (m_cfg[0] && m_cfg[1]) ? (de ^ m_cfg[2]) : modem_rts;
      chk("drv_en", {15'd0, drv_en}, {15'd0, de});
      chk("rts_out", {15'd0, rts_out}, {15'd0, rts});
      chk("cfg_rdata", cfg_rdata, m_cfg);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step(1);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic frame(input int len);
    tx_fifo_empty = 1'b0;
    step(1);
    tx_fifo_empty = 1'b1; tx_shift_busy = 1'b1;
    step(len);
    tx_shift_busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, modem level passes through
    tag = "R1";
    step(3); modem_rts = 1'b1; step(2); modem_rts = 1'b0; step(2);
    // R2: mask and readback
    tag = "R2";
    wr(16'hFFFF); step(2);
    wr(16'h0A05); step(2);
    wr(16'h0000); step(2);
    // R3 R4 R5: enable + route, delay 3, ticks running
    tick_on = 1'b1;
    tag = "R3"; wr(16'h0303); step(3);
    tag = "R4"; frame(20);
    tag = "R5"; step(25);
    // R6: zero delay
    tag = "R6"; wr(16'h0003); step(2); frame(9); step(6);
    // R5: maximum delay 15
    tag = "R5"; wr(16'h0F03); step(2); frame(7); step(70);
    // R7: data returns during the hold
    tag = "R7"; wr(16'h0603); step(2); frame(8); step(9); frame(5); step(40);
    // R8: inverted polarity
    tag = "R8"; wr(16'h0207); step(2); modem_rts = 1'b1; frame(10); step(15);
    // R9: route off while enabled, then enable cleared mid-frame and mid-hold
    tag = "R9"; wr(16'h0201); step(2); frame(6); step(12);
    modem_rts = 1'b0;
    wr(16'h0403); step(1); tx_fifo_empty = 1'b0; step(2);
    wr(16'h0402); step(3); tx_fifo_empty = 1'b1; step(3);
    wr(16'h0403); step(2); frame(4); step(2); wr(16'h0402); step(3);
    wr(16'h0403); step(20);
    // R10: ticks while idle and during a long frame do nothing
    tag = "R10"; wr(16'h0203); step(30); frame(40); step(20);
    tick_on = 1'b0;
    tag = "R5"; frame(4); step(12); tick_on = 1'b1; step(20);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule